// File: doc/BRIEF.md
# Sensor Front-End Aligner with Latency Buffer and Accept-Gated Derandomizer

This block sits right after the digitisers of a group of sensor channels and runs at the sample rate, taking one new word per channel on every clock. Each channel is captured in a register on entry. Each channel then passes through its own fixed delay, so that samples belonging to one bunch crossing emerge together. From the aligned samples the block cuts a fixed-position field out of every channel and registers the fields side by side as a trigger word. The trigger logic downstream uses this word to make its decision.

The full aligned word of all channels goes into a ring buffer. The buffer is read at a tap exactly as old as the trigger latency. When the first-level accept arrives, the tapped event is copied into a small derandomizer FIFO, but only if that FIFO has room. A refused accept sets a sticky overflow flag and is counted. A serializer takes events from the FIFO one at a time. It sends each event as a one-bit stream: a start marker first, then the event word from its most significant bit down. The stream uses valid/ready. The sink may hold ready low for as long as it likes, and the bit on offer stays put until it is taken. The sample inputs and the accept cannot be held back, so back-pressure from acquisition is absorbed by the FIFO alone. Once the FIFO is full, further accepts are lost.

The channel delays, the trigger-field position and width, the latency, the FIFO depth and the counter width are all elaboration parameters of the top module.

Top module: `fe_derand_front`

## Requirements
- R1: While reset is held low, trig_word is zero, ser_valid and ser_busy are low, ovf_flag is low and drop_cnt is zero.
- R2: Channel c occupies bits [c*CW +: CW] of chan_data and has a delay Dc taken from bits [c*DLY_W +: DLY_W] of CH_DLY. The trig_word value registered at clock edge k carries, for channel c, the sample that was presented at edge k-1-Dc.
- R3: The field of channel c in trig_word is bits [c*TW_W +: TW_W]. It holds bits [TW_LSB +: TW_W] of that channel's aligned sample.
- R4: An accept sampled at edge x selects, for every channel c, the sample presented at edge x-LAT-1-Dc. This is the event whose trigger word was registered LAT edges earlier. In the event word, channel c occupies bits [c*CW +: CW].
- R5: An accept is stored in the FIFO only when the FIFO is not full. Accepts that arrive while there is room are all delivered, including accepts on consecutive cycles. A refused accept leaves the events already held untouched.
- R6: Each refused accept raises ovf_flag, which stays high until reset, and adds one to drop_cnt. drop_cnt does not change in a cycle without an accept.
- R7: Each event leaves as EW+1 beats: a start marker bit of 1, then event bits EW-1 down to 0.
- R8: A beat transfers on a clock edge where ser_valid and ser_ready are both high. While ser_valid is high and ser_ready is low, ser_valid stays high and ser_bit keeps its value.
- R9: Events leave in the order they were accepted. ser_busy is high from the marker beat until the handshake of the last data bit, and it is low once the FIFO and serializer are empty.
- R10: Without any accept the stream stays idle, with no beat offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_data | input | NCH*CW | One digitised sample per channel, new every cycle |
| l1_accept | input | 1 | First-level accept for the crossing at the latency tap |
| trig_word | output | NCH*TW_W | Registered fields cut from the aligned channels |
| ser_valid | output | 1 | A stream bit is on offer |
| ser_ready | input | 1 | Acquisition takes the offered bit |
| ser_bit | output | 1 | Stream bit: marker, then event bits MSB first |
| ser_busy | output | 1 | An event is being sent |
| ovf_flag | output | 1 | Sticky: an accept was refused because the FIFO was full |
| drop_cnt | output | DROP_W | Number of refused accepts, saturating |

## Verification
A wrong delay in one channel shows up in trig_word within a few cycles: that channel's field holds the neighbouring crossing's value while the other fields are right. A latency tap that is off by one, or a ring pointer that wraps wrongly, only shows when an accepted event comes out on the stream. That frame has the wrong content, roughly EW+1 handshakes after the accept. A FIFO count that drifts shows when the first accept is refused too early or too late, through drop_cnt and ovf_flag. It also shows as a missing or duplicated frame once acquisition drains the FIFO. A shift or marker error in the serializer corrupts the very next frame.

// File: rtl/fe_pkg.sv
package fe_pkg;

  // Serializer phases: waiting for an event, offering the start marker,
  // shifting out the event word.
  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_MARK = 2'd1,
    SER_DATA = 2'd2
  } ser_state_e;

  // Bits needed to index n entries (at least one bit).
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/fe_chan_align.sv
// One channel: entry register followed by a fixed delay line.
module fe_chan_align #(
  parameter int unsigned CW  = 8,
  parameter int unsigned DLY = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] dout
);

  logic [CW-1:0] entry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) entry_q <= '0;
    else        entry_q <= din;
  end

  generate
    if (DLY == 0) begin : g_nodly
      assign dout = entry_q;
    end else begin : g_dly
      logic [CW-1:0] stage_q [DLY];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DLY; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= entry_q;
          for (int i = 1; i < DLY; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign dout = stage_q[DLY-1];
    end
  endgenerate

endmodule

// File: rtl/fe_pipe_buf.sv
// Latency buffer: a ring written every cycle; the read tap is the slot about
// to be overwritten, i.e. the word written LAT edges ago.
module fe_pipe_buf
  import fe_pkg::*;
#(
  parameter int unsigned EW  = 32,
  parameter int unsigned LAT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] wr_word,
  output logic [EW-1:0] tap_word
);

  localparam int unsigned PW = idx_bits(LAT);

  logic [EW-1:0] ring_q [LAT];
  logic [PW-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      for (int i = 0; i < LAT; i++) ring_q[i] <= '0;
    end else begin
      ring_q[slot_q] <= wr_word;
      slot_q         <= (slot_q == PW'(LAT - 1)) ? '0 : slot_q + 1'b1;
    end
  end

  assign tap_word = ring_q[slot_q];

endmodule

// File: rtl/fe_derand_fifo.sv
// Derandomizer: writes refused while full, refusals flagged and counted.
module fe_derand_fifo
  import fe_pkg::*;
#(
  parameter int unsigned EW     = 32,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DROP_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_req,
  input  logic [EW-1:0]               wr_data,
  input  logic                        rd_pop,
  output logic [EW-1:0]               rd_data,
  output logic                        empty,
  output logic                        full,
  output logic [$clog2(DEPTH+1)-1:0]  count,
  output logic                        ovf,
  output logic [DROP_W-1:0]           drops
);

  localparam int unsigned AW   = idx_bits(DEPTH);
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic [EW-1:0]   mem_q [DEPTH];
  logic [AW-1:0]   wp_q, rp_q;
  logic [CNTW-1:0] cnt_q;
  logic            wr_en, rd_en;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CNTW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_en = wr_req && !full;
  assign rd_en = rd_pop && !empty;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wp_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf   <= 1'b0;
      drops <= '0;
    end else begin
      if (wr_en) wp_q <= bump(wp_q);
      if (rd_en) rp_q <= bump(rp_q);
      cnt_q <= cnt_q + CNTW'(wr_en) - CNTW'(rd_en);
      if (wr_req && full) begin
        ovf <= 1'b1;
        if (drops != '1) drops <= drops + 1'b1;
      end
    end
  end

  assign rd_data = mem_q[rp_q];
  assign count   = cnt_q;

endmodule

// File: rtl/fe_serializer.sv
// One-bit valid/ready stream: marker 1, then the event word MSB first.
module fe_serializer
  import fe_pkg::*;
#(
  parameter int unsigned EW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_empty,
  input  logic [EW-1:0] src_word,
  output logic          src_pop,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_bit,
  output logic          busy
);

  localparam int unsigned BW = idx_bits(EW);

  ser_state_e    state_q;
  logic [EW-1:0] shift_q;
  logic [BW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      shift_q <= '0;
      left_q  <= '0;
    end else begin
      case (state_q)
        SER_IDLE: begin
          if (!src_empty) begin
            shift_q <= src_word;
            state_q <= SER_MARK;
          end
        end
        SER_MARK: begin
          if (out_ready) begin
            left_q  <= BW'(EW - 1);
            state_q <= SER_DATA;
          end
        end
        SER_DATA: begin
          if (out_ready) begin
            if (left_q == '0) begin
              state_q <= SER_IDLE;
            end else begin
              shift_q <= {shift_q[EW-2:0], 1'b0};
              left_q  <= left_q - 1'b1;
            end
          end
        end
        default: state_q <= SER_IDLE;
      endcase
    end
  end

  assign src_pop   = (state_q == SER_IDLE) && !src_empty;
  assign out_valid = (state_q != SER_IDLE);
  assign out_bit   = (state_q == SER_MARK) ? 1'b1 : shift_q[EW-1];
  assign busy      = (state_q != SER_IDLE);

endmodule

// File: rtl/fe_derand_front.sv
module fe_derand_front
  import fe_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CW     = 8,
  parameter int unsigned DLY_W  = 3,
  parameter logic [NCH*DLY_W-1:0] CH_DLY = {3'd3, 3'd0, 3'd2, 3'd1},
  parameter int unsigned TW_LSB = 4,
  parameter int unsigned TW_W   = 4,
  parameter int unsigned LAT    = 8,
  parameter int unsigned FDEPTH = 4,
  parameter int unsigned DROP_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH*CW-1:0]    chan_data,
  input  logic                 l1_accept,
  output logic [NCH*TW_W-1:0]  trig_word,
  output logic                 ser_valid,
  input  logic                 ser_ready,
  output logic                 ser_bit,
  output logic                 ser_busy,
  output logic                 ovf_flag,
  output logic [DROP_W-1:0]    drop_cnt
);

  localparam int unsigned EW   = NCH * CW;
  localparam int unsigned TWW  = NCH * TW_W;
  localparam int unsigned CNTW = $clog2(FDEPTH + 1);

  logic [EW-1:0]   aligned;
  logic [TWW-1:0]  tw_next;
  logic [EW-1:0]   tap_word;
  logic [EW-1:0]   head_word;
  logic            fifo_empty, fifo_full, ser_pop;
  logic [CNTW-1:0] fifo_cnt;

  // Per-channel alignment and trigger-field extraction.
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned D = int'(CH_DLY[c*DLY_W +: DLY_W]);
    fe_chan_align #(.CW(CW), .DLY(D)) u_align (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (chan_data[c*CW +: CW]),
      .dout (aligned[c*CW +: CW])
    );
    assign tw_next[c*TW_W +: TW_W] = aligned[c*CW + TW_LSB +: TW_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_word <= '0;
    else        trig_word <= tw_next;
  end

  fe_pipe_buf #(.EW(EW), .LAT(LAT)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_word (aligned),
    .tap_word(tap_word)
  );

  fe_derand_fifo #(.EW(EW), .DEPTH(FDEPTH), .DROP_W(DROP_W)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_req (l1_accept),
    .wr_data(tap_word),
    .rd_pop (ser_pop),
    .rd_data(head_word),
    .empty  (fifo_empty),
    .full   (fifo_full),
    .count  (fifo_cnt),
    .ovf    (ovf_flag),
    .drops  (drop_cnt)
  );

  fe_serializer #(.EW(EW)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_empty(fifo_empty),
    .src_word (head_word),
    .src_pop  (ser_pop),
    .out_valid(ser_valid),
    .out_ready(ser_ready),
    .out_bit  (ser_bit),
    .busy     (ser_busy)
  );

endmodule

// File: rtl/fe_derand_front_chk.sv
module fe_derand_front_chk #(
  parameter int unsigned FDEPTH = 4,
  parameter int unsigned DROP_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       l1_accept,
  input logic                       ser_valid,
  input logic                       ser_ready,
  input logic                       ser_bit,
  input logic                       ser_busy,
  input logic                       ovf_flag,
  input logic [DROP_W-1:0]          drop_cnt,
  input logic                       fifo_full,
  input logic [$clog2(FDEPTH+1)-1:0] fifo_cnt
);

  localparam int unsigned CNTW = $clog2(FDEPTH + 1);

  // R8: a stalled beat is held unchanged
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !ser_ready) |=> (ser_valid && $stable(ser_bit)));

  // R6: overflow flag is sticky
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  // R6: an accept met by a full FIFO is flagged and counted
  assert_refuse_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_accept && fifo_full) |=> (ovf_flag && drop_cnt != '0));

  // R6: no accept, no change in the drop count
  assert_drop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !l1_accept |=> $stable(drop_cnt));

  // R5: occupancy never exceeds the depth
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNTW'(FDEPTH));

  // R9: busy ends only after a completed handshake
  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_busy) |-> $past(ser_valid && ser_ready));

endmodule

bind fe_derand_front fe_derand_front_chk #(.FDEPTH(FDEPTH), .DROP_W(DROP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .l1_accept(l1_accept),
  .ser_valid(ser_valid),
  .ser_ready(ser_ready),
  .ser_bit  (ser_bit),
  .ser_busy (ser_busy),
  .ovf_flag (ovf_flag),
  .drop_cnt (drop_cnt),
  .fifo_full(fifo_full),
  .fifo_cnt (fifo_cnt)
);

// File: tb/fe_derand_front_tb.sv
module fe_derand_front_tb;

  localparam int unsigned NCH    = 4;
  localparam int unsigned CW     = 8;
  localparam int unsigned DLY_W  = 3;
  localparam logic [NCH*DLY_W-1:0] CH_DLY = {3'd3, 3'd0, 3'd2, 3'd1};
  localparam int unsigned TW_LSB = 4;
  localparam int unsigned TW_W   = 4;
  localparam int unsigned LAT    = 8;
  localparam int unsigned FDEPTH = 4;
  localparam int unsigned DROP_W = 8;
  localparam int unsigned EW     = NCH * CW;
  localparam int unsigned TWW    = NCH * TW_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [EW-1:0]     chan_data = '0;
  logic              l1_accept = 1'b0;
  logic              ser_ready = 1'b0;
  logic [TWW-1:0]    trig_word;
  logic              ser_valid, ser_bit, ser_busy, ovf_flag;
  logic [DROP_W-1:0] drop_cnt;

  fe_derand_front #(
    .NCH(NCH), .CW(CW), .DLY_W(DLY_W), .CH_DLY(CH_DLY), .TW_LSB(TW_LSB),
    .TW_W(TW_W), .LAT(LAT), .FDEPTH(FDEPTH), .DROP_W(DROP_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_data(chan_data), .l1_accept(l1_accept),
    .trig_word(trig_word), .ser_valid(ser_valid), .ser_ready(ser_ready),
    .ser_bit(ser_bit), .ser_busy(ser_busy), .ovf_flag(ovf_flag),
    .drop_cnt(drop_cnt)
  );

  always #2 clk = ~clk;  // 250 MHz

  int n_chk = 0, n_fail = 0;
  int e_cnt = 0;
  int frames = 0;
  bit tw_on = 0, drop_next = 0, done = 0;
  bit in_frame = 0, prev_stall = 0;
  logic prev_bit = 1'b0;
  int nb = 0;
  logic [EW-1:0] word = '0;
  logic [EW-1:0] hist [64];
  logic [EW-1:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int dly_of(input int c);
    return int'(CH_DLY[c*DLY_W +: DLY_W]);
  endfunction

  // Trigger word registered at edge k (R2, R3)
  function automatic logic [TWW-1:0] exp_tw(input int k);
    logic [TWW-1:0] r;
    for (int c = 0; c < NCH; c++)
      r[c*TW_W +: TW_W] = hist[(k - 1 - dly_of(c)) & 63][c*CW + TW_LSB +: TW_W];
    return r;
  endfunction

  // Event selected by an accept at edge x (R4)
  function automatic logic [EW-1:0] exp_ev(input int x);
    logic [EW-1:0] r;
    for (int c = 0; c < NCH; c++)
      r[c*CW +: CW] = hist[(x - int'(LAT) - 1 - dly_of(c)) & 63][c*CW +: CW];
    return r;
  endfunction

  always @(posedge clk) e_cnt++;

  // Monitor, away from the active edge
  always @(negedge clk) begin
    int nxt;
    logic [EW-1:0] e;
    nxt = e_cnt + 1;
    hist[nxt & 63] = chan_data;
    if (tw_on) chk(trig_word == exp_tw(e_cnt), "R2,R3", "trig_word", 64'(trig_word), 64'(exp_tw(e_cnt)));
    if (prev_stall) chk(ser_valid && ser_bit == prev_bit, "R8", "held beat", {ser_valid, ser_bit}, {1'b1, prev_bit});
    prev_stall = ser_valid && !ser_ready;
    prev_bit = ser_bit;
    if (rst_n && l1_accept && !drop_next) exp_q.push_back(exp_ev(nxt));
    if (ser_valid && ser_ready) begin
      if (!in_frame) begin
        chk(ser_bit == 1'b1, "R7", "start marker", 64'(ser_bit), 64'd1);
        chk(ser_busy == 1'b1, "R9", "busy at marker", 64'(ser_busy), 64'd1);
        in_frame = 1;
        nb = 0;
        word = '0;
      end else begin
        word = {word[EW-2:0], ser_bit};
        nb++;
        if (nb == int'(EW)) begin
          in_frame = 0;
          frames++;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R5", "unexpected frame", 64'(word), 64'd0);
          end else begin
            e = exp_q.pop_front();
            chk(word == e, "R4,R7", "frame content", 64'(word), 64'(e));
          end
        end
      end
    end
  end

  task automatic step(input bit acc, input bit rdy);
    @(posedge clk);
    #1;
    chan_data = EW'({$urandom, $urandom});
    l1_accept = acc;
    ser_ready = rdy;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((exp_q.size() != 0 || in_frame) && t < 4000) begin
      step(1'b0, 1'b1);
      t++;
    end
    repeat (3) step(1'b0, 1'b1);
  endtask

  initial begin
    int gap, next_gap, f0;
    void'($urandom(32'd20240));
    for (int i = 0; i < 64; i++) hist[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(trig_word == '0, "R1", "trig_word in reset", 64'(trig_word), 64'd0);
    chk(!ser_valid && !ser_busy, "R1", "stream idle in reset", {ser_valid, ser_busy}, 64'd0);
    chk(!ovf_flag && drop_cnt == '0, "R1", "overflow state in reset", {ovf_flag, drop_cnt}, 64'd0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    tw_on = 1;

    // R10: no accept, no frame
    repeat (40) step(1'b0, 1'b1);
    chk(frames == 0 && !ser_valid, "R10", "idle without accept", 64'(frames), 64'd0);

    // Random phase: sparse accepts, random back-pressure (R4, R7, R8, R9)
    gap = 0;
    next_gap = 100 + int'($urandom % 40);
    for (int i = 0; i < 3000; i++) begin
      bit a;
      a = (gap >= next_gap);
      if (a) begin
        gap = 0;
        next_gap = 100 + int'($urandom % 40);
      end else gap++;
      step(a, ($urandom % 4) != 0);
    end
    drain();
    chk(exp_q.size() == 0, "R9", "all accepted events delivered", 64'(exp_q.size()), 64'd0);
    chk(drop_cnt == '0 && !ovf_flag, "R5", "no refusal with room", {ovf_flag, drop_cnt}, 64'd0);
    chk(frames > 10, "R9", "frames seen", 64'(frames), 64'd11);

    // R5: accepts on consecutive cycles
    f0 = frames;
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    drain();
    chk(frames - f0 == 2, "R5", "consecutive accepts", 64'(frames - f0), 64'd2);

    // R5, R6: overflow with acquisition stalled
    f0 = frames;
    for (int i = 0; i < int'(FDEPTH) + 3; i++) begin
      drop_next = (i >= int'(FDEPTH) + 1);
      step(1'b1, 1'b0);
      drop_next = 0;
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
    end
    @(negedge clk);
    chk(drop_cnt == DROP_W'(2), "R6", "drop count", 64'(drop_cnt), 64'd2);
    chk(ovf_flag == 1'b1, "R6", "overflow flag", 64'(ovf_flag), 64'd1);
    chk(ser_valid && ser_bit, "R8", "marker held under stall", {ser_valid, ser_bit}, 64'd3);
    drain();
    chk(frames - f0 == int'(FDEPTH) + 1, "R5", "stored events after refusal", 64'(frames - f0), 64'(FDEPTH + 1));
    chk(ser_busy == 1'b0, "R9", "busy low when empty", 64'(ser_busy), 64'd0);
    chk(ovf_flag == 1'b1, "R6", "overflow flag sticky", 64'(ovf_flag), 64'd1);
    chk(drop_cnt == DROP_W'(2), "R6", "drop count stable", 64'(drop_cnt), 64'd2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule